// File: doc/BRIEF.md
# Video frame sync generator

This block produces the line, field and frame timing for an interlaced video encoder that runs from a 27 MHz sample clock. It keeps a sample counter and a line counter for either the 525-line or the 625-line system. From these counters it decodes the field parity, a sync pulse, a vertical blanking flag, an active-picture flag and the field index inside the colour burst sequence. The burst sequence is four fields long for 525 lines and eight fields long for 625 lines.

In master mode the counters run freely from a software reset, and the block drives the field-parity pin. In slave mode the block stays parked until the chosen edge of the external field-parity pulse arrives. That pulse is first passed through a two-stage synchroniser. Each selected edge restarts the frame. If three whole frames go by with no edge, the lock status drops. The timing then either carries on by itself (free-run) or the sync output is silenced and a black request is raised. All geometry is set by parameters, so a bench can work with shortened lines and frames.

Top module: `frame_timing_gen`

## Requirements
- R1: `sample_no` counts 0 to L-1 and `line_no` counts 1 to N. On the last sample of line N both return to sample 0, line 1. With `std_625`=0, L=1716 and N=525; with `std_625`=1, L=1728 and N=625.
- R2: `vblank` is 1 on exactly these lines and 0 on all others. For 525 lines: 1–9 and 264–272. For 625 lines: 624–625, 1–5 and 311–318.
- R3: With `master`=1, a `soft_rst` pulse puts the counters at line 1, sample 0 in the following cycle, and they advance one sample per clock after that. `fp_oe` is 1. Edges on `fp_in` have no effect on the counters.
- R4: `fp_out` equals `par_inv` on the first field and the inverse of `par_inv` on the second field. The second field starts at line 264 (525) or line 313 (625).
- R5: `burst_phase` is 0 on the field that begins at a restart. It advances by one at the start of every field and wraps modulo 4 for 525 lines and modulo 8 for 625 lines.
- R6: With `master`=0, after `soft_rst` the counters hold at line 1, sample 0, `black` is 1 and `sync_out` sits at its inactive level. This lasts until the selected edge of `fp_in` arrives: falling when `par_inv`=0, rising when `par_inv`=1. Each selected edge sets line 1, sample 0 on the third rising clock edge after `fp_in` changes. The opposite edge is ignored.
- R7: In slave mode, `locked` goes to 1 on a selected edge. It goes to 0 at the frame wrap that ends the third consecutive frame with no edge; the frame that holds the edge does not count. After that the counters keep running. With `freerun_en`=1, sync continues and `black` stays 0. With `freerun_en`=0, `black` is 1 and `sync_out` equals `sync_neg`. In master mode `locked` is 0.
- R8: With `hsel`=1, the sync pulse is active on samples 0 to 126 of every line. With `hsel`=0 it is composite: that pulse is inverted on lines 3 to 5 of each field, counting from the field's first line as 0. `sync_neg`=1 inverts the output, so active becomes low.
- R9: `active` is 1 only on lines where `vblank` is 0, for 1440 samples. These start at sample 244 (525) or 264 (625) in slave mode, and 2 samples later in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Restart the timing sequence (one-cycle pulse) |
| std_625 | input | 1 | 0: 525-line system, 1: 625-line system |
| master | input | 1 | 1: free counting and drive field parity; 0: lock to fp_in |
| freerun_en | input | 1 | Keep generating timing after lock loss |
| par_inv | input | 1 | Field-parity polarity and slave edge select |
| sync_neg | input | 1 | Sync output active low when 1 |
| hsel | input | 1 | 1: line sync only, 0: composite sync |
| fp_in | input | 1 | External field-parity pulse (slave) |
| fp_out | output | 1 | Field parity |
| fp_oe | output | 1 | Drive enable for fp_out |
| sync_out | output | 1 | Sync pulse |
| vblank | output | 1 | Vertical blanking line flag |
| active | output | 1 | Active picture sample flag |
| black | output | 1 | Request to force video outputs to black |
| burst_phase | output | 3 | Field index within burst sequence |
| line_no | output | 10 | Line number, 1-based |
| sample_no | output | 11 | Sample number within the line |
| locked | output | 1 | Slave frame lock status |

## Verification
Some properties are checked on every clock. The sample count stays in range and steps by one while it runs. It holds still while parked. A frame wrap is followed by line 1, sample 0. The selected field edge never fires on two cycles in a row. Lock and loss are never true together, and lock only drops at a frame wrap. The parity output changes only at a line start. A black request always silences sync, and the active flag never rises on a blanked line. Other behaviour needs the directed scenarios: the exact blanking line ranges, the burst sequence length, composite sync serration, the three-cycle restart latency after a field edge, rejection of the opposite edge, and the count of three empty frames before lock is lost, with and without free-run.

// File: rtl/ftg_pkg.sv
// Shared types for the frame timing generator.
package ftg_pkg;
    // Run state of the counter chain: parked waiting for a start, or counting.
    typedef enum logic {
        SYNC_WAIT = 1'b0,
        SYNC_RUN  = 1'b1
    } sync_state_e;
endpackage

// File: rtl/ftg_fp_sync.sv
// Field-parity input synchroniser and edge detector.
// Assumes fp pin is asynchronous to clk; two flops resolve it, a third keeps
// the previous value. rise_sel picks which transition produces edge_o.
module ftg_fp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_o
);
    logic s1_q, s2_q, s3_q;

    // Two-flop synchroniser plus history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Edge of the selected direction on the synchronised signal.
    assign edge_o = rise_sel ? (s2_q & ~s3_q) : (~s2_q & s3_q);

    // One direction only can fire, so two edges can never be adjacent.
    assert_edge_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(rise_sel)) |=> !edge_o);
endmodule

// File: rtl/ftg_timebase.sv
// Sample, line and burst-field counters.
// Assumes load has priority over run; std_625 picks line length, line count
// and the first line of the second field. burst_phase counts fields modulo 4
// (525) or 8 (625) and clears on load.
module ftg_timebase #(
    parameter int SAMPLES_525 = 1716,
    parameter int LINES_525   = 525,
    parameter int SAMPLES_625 = 1728,
    parameter int LINES_625   = 625,
    parameter int FLD2_525    = 264,
    parameter int FLD2_625    = 313,
    parameter int SW          = 11,
    parameter int LW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_625,
    input  logic          load,
    input  logic          run,
    output logic [SW-1:0] sample_no,
    output logic [LW-1:0] line_no,
    output logic [2:0]    burst_phase,
    output logic          frame_wrap
);
    localparam logic [SW-1:0] LAST_S5 = SW'(SAMPLES_525 - 1);
    localparam logic [SW-1:0] LAST_S6 = SW'(SAMPLES_625 - 1);
    localparam logic [LW-1:0] LAST_L5 = LW'(LINES_525);
    localparam logic [LW-1:0] LAST_L6 = LW'(LINES_625);
    localparam logic [LW-1:0] F2_5    = LW'(FLD2_525);
    localparam logic [LW-1:0] F2_6    = LW'(FLD2_625);
    localparam int SAMP_MAX = (SAMPLES_525 > SAMPLES_625) ? SAMPLES_525 : SAMPLES_625;
    localparam logic [SW-1:0] S_LIMIT = SW'(SAMP_MAX);

    logic [SW-1:0] sample_q, last_s;
    logic [LW-1:0] line_q, last_l, fld2;
    logic [2:0]    bp_q, bp_mask, bp_next;
    logic          line_end, frame_end;

    // Standard-dependent limits.
    always_comb begin
        last_s  = std_625 ? LAST_S6 : LAST_S5;
        last_l  = std_625 ? LAST_L6 : LAST_L5;
        fld2    = std_625 ? F2_6 : F2_5;
        bp_mask = std_625 ? 3'd7 : 3'd3;
        bp_next = (bp_q + 3'd1) & bp_mask;
    end

    assign line_end   = sample_q >= last_s;
    assign frame_end  = line_end && (line_q >= last_l);
    assign frame_wrap = run && !load && frame_end;

    // Counter chain: sample within line, line within frame, field in burst run.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sample_q <= '0;
            line_q   <= LW'(1);
            bp_q     <= '0;
        end else if (run) begin
            if (line_end) begin
                sample_q <= '0;
                if (line_q >= last_l) begin
                    line_q <= LW'(1);
                    bp_q   <= bp_next;
                end else begin
                    line_q <= line_q + LW'(1);
                    if (line_q + LW'(1) == fld2)
                        bp_q <= bp_next;
                end
            end else begin
                sample_q <= sample_q + SW'(1);
            end
        end
    end

    assign sample_no   = sample_q;
    assign line_no     = line_q;
    assign burst_phase = bp_q;

    assert_sample_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_q < S_LIMIT);
    assert_sample_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !line_end) |=> sample_q == $past(sample_q) + SW'(1));
    assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (line_q == LW'(1) && sample_q == '0));
    assert_park_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> ($stable(sample_q) && $stable(line_q)));
endmodule

// File: rtl/ftg_lock.sv
// Run state and slave lock tracking.
// Assumes edge_i is already synchronised. In slave mode the chain parks after
// soft_rst until an edge; lock is lost after LOST_FRAMES frame wraps with no
// edge, not counting the frame that held the last edge.
module ftg_lock #(
    parameter int LOST_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic master,
    input  logic freerun_en,
    input  logic edge_i,
    input  logic frame_wrap,
    output logic load,
    output logic run,
    output logic locked,
    output logic stopped
);
    import ftg_pkg::*;

    localparam int MW = $clog2(LOST_FRAMES + 1);
    localparam logic [MW-1:0] MISS_MAX = MW'(LOST_FRAMES);

    sync_state_e   state_q;
    logic [MW-1:0] miss_q;
    logic          seen_q, locked_q, lost;

    assign load    = soft_rst || (!master && edge_i);
    assign run     = (state_q == SYNC_RUN) || master;
    assign lost    = (miss_q == MISS_MAX);
    assign stopped = !master && ((state_q == SYNC_WAIT) || (lost && !freerun_en));
    assign locked  = locked_q;

    // Park on reset, start on master mode or on a field edge.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            state_q <= SYNC_WAIT;
        else if (master || edge_i)
            state_q <= SYNC_RUN;
    end

    // Count frames that ended with no field edge; drive lock status.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || master) begin
            miss_q   <= '0;
            seen_q   <= 1'b0;
            locked_q <= 1'b0;
        end else if (edge_i) begin
            miss_q   <= '0;
            seen_q   <= 1'b1;
            locked_q <= 1'b1;
        end else if (frame_wrap) begin
            if (seen_q) begin
                seen_q <= 1'b0;
                miss_q <= '0;
            end else if (!lost) begin
                miss_q <= miss_q + MW'(1);
                if (miss_q + MW'(1) == MISS_MAX)
                    locked_q <= 1'b0;
            end
        end
    end

    assert_lock_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_q && lost));
    assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_q) |-> ($past(frame_wrap) || $past(soft_rst) || $past(master)));
endmodule

// File: rtl/ftg_decode.sv
// Output decode from the counters: sync, parity, blanking and active flags.
// Assumes line_no is 1-based and sample_no 0-based; purely combinational, the
// clock is only used by the checks.
module ftg_decode #(
    parameter int FLD2_525    = 264,
    parameter int FLD2_625    = 313,
    parameter int HS_LEN      = 127,
    parameter int VS_OFS      = 3,
    parameter int VS_LINES    = 3,
    parameter int ACT_LEN     = 1440,
    parameter int ACT_525     = 244,
    parameter int ACT_625     = 264,
    parameter int VB_END_525  = 9,
    parameter int VB2_END_525 = 272,
    parameter int VB_HEAD_625 = 624,
    parameter int VB_END_625  = 5,
    parameter int VB2_BEG_625 = 311,
    parameter int VB2_END_625 = 318,
    parameter int SW          = 11,
    parameter int LW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_625,
    input  logic          master,
    input  logic          hsel,
    input  logic          sync_neg,
    input  logic          par_inv,
    input  logic          stopped,
    input  logic [SW-1:0] sample_no,
    input  logic [LW-1:0] line_no,
    output logic          sync_out,
    output logic          fp_out,
    output logic          vblank,
    output logic          active
);
    localparam logic [LW-1:0] F2_5   = LW'(FLD2_525);
    localparam logic [LW-1:0] F2_6   = LW'(FLD2_625);
    localparam logic [LW-1:0] VBE5   = LW'(VB_END_525);
    localparam logic [LW-1:0] VB2E5  = LW'(VB2_END_525);
    localparam logic [LW-1:0] VBH6   = LW'(VB_HEAD_625);
    localparam logic [LW-1:0] VBE6   = LW'(VB_END_625);
    localparam logic [LW-1:0] VB2B6  = LW'(VB2_BEG_625);
    localparam logic [LW-1:0] VB2E6  = LW'(VB2_END_625);
    localparam logic [LW-1:0] VS_B   = LW'(VS_OFS);
    localparam logic [LW-1:0] VS_E   = LW'(VS_OFS + VS_LINES);
    localparam logic [SW-1:0] HS_E   = SW'(HS_LEN);
    localparam logic [SW-1:0] AS5    = SW'(ACT_525);
    localparam logic [SW-1:0] AS6    = SW'(ACT_625);
    localparam logic [SW-1:0] ALEN   = SW'(ACT_LEN);

    logic [LW-1:0] fld2, rel;
    logic [SW-1:0] act_s, act_e;
    logic          field2, hs, vs, sync_raw;

    // Field, blanking and parity decode from the line count.
    always_comb begin
        fld2   = std_625 ? F2_6 : F2_5;
        field2 = line_no >= fld2;
        rel    = field2 ? (line_no - fld2) : (line_no - LW'(1));
        if (std_625)
            vblank = (line_no >= VBH6) || (line_no <= VBE6) ||
                     ((line_no >= VB2B6) && (line_no <= VB2E6));
        else
            vblank = (line_no <= VBE5) || ((line_no >= F2_5) && (line_no <= VB2E5));
        fp_out = field2 ^ par_inv;
    end

    // Sync pulse and active window decode from the sample count.
    always_comb begin
        hs       = sample_no < HS_E;
        vs       = (rel >= VS_B) && (rel < VS_E);
        sync_raw = hsel ? hs : (hs ^ vs);
        sync_out = (stopped ? 1'b0 : sync_raw) ^ sync_neg;
        act_s    = (std_625 ? AS6 : AS5) + (master ? SW'(2) : SW'(0));
        act_e    = act_s + ALEN;
        active   = !vblank && (sample_no >= act_s) && (sample_no < act_e);
    end

    assert_active_unblanked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !vblank);
endmodule

// File: rtl/frame_timing_gen.sv
// Frame timing generator top: field-edge synchroniser, lock tracker,
// counter chain and output decode. Assumes clk is the 27 MHz sample clock and
// configuration inputs change only around a soft_rst.
module frame_timing_gen #(
    parameter int SAMPLES_525 = 1716,
    parameter int LINES_525   = 525,
    parameter int SAMPLES_625 = 1728,
    parameter int LINES_625   = 625,
    parameter int FLD2_525    = 264,
    parameter int FLD2_625    = 313,
    parameter int HS_LEN      = 127,
    parameter int VS_OFS      = 3,
    parameter int VS_LINES    = 3,
    parameter int ACT_LEN     = 1440,
    parameter int ACT_525     = 244,
    parameter int ACT_625     = 264,
    parameter int VB_END_525  = 9,
    parameter int VB2_END_525 = 272,
    parameter int VB_HEAD_625 = 624,
    parameter int VB_END_625  = 5,
    parameter int VB2_BEG_625 = 311,
    parameter int VB2_END_625 = 318,
    parameter int LOST_FRAMES = 3,
    localparam int SW = $clog2((SAMPLES_525 > SAMPLES_625) ? SAMPLES_525 : SAMPLES_625),
    localparam int LW = $clog2(((LINES_525 > LINES_625) ? LINES_525 : LINES_625) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          std_625,
    input  logic          master,
    input  logic          freerun_en,
    input  logic          par_inv,
    input  logic          sync_neg,
    input  logic          hsel,
    input  logic          fp_in,
    output logic          fp_out,
    output logic          fp_oe,
    output logic          sync_out,
    output logic          vblank,
    output logic          active,
    output logic          black,
    output logic [2:0]    burst_phase,
    output logic [LW-1:0] line_no,
    output logic [SW-1:0] sample_no,
    output logic          locked
);
    logic fp_edge, load, run, stopped, frame_wrap;

    ftg_fp_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (fp_in),
        .rise_sel (par_inv),
        .edge_o   (fp_edge)
    );

    ftg_lock #(.LOST_FRAMES(LOST_FRAMES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .master     (master),
        .freerun_en (freerun_en),
        .edge_i     (fp_edge),
        .frame_wrap (frame_wrap),
        .load       (load),
        .run        (run),
        .locked     (locked),
        .stopped    (stopped)
    );

    ftg_timebase #(
        .SAMPLES_525 (SAMPLES_525), .LINES_525 (LINES_525),
        .SAMPLES_625 (SAMPLES_625), .LINES_625 (LINES_625),
        .FLD2_525    (FLD2_525),    .FLD2_625  (FLD2_625),
        .SW          (SW),          .LW        (LW)
    ) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .std_625     (std_625),
        .load        (load),
        .run         (run),
        .sample_no   (sample_no),
        .line_no     (line_no),
        .burst_phase (burst_phase),
        .frame_wrap  (frame_wrap)
    );

    ftg_decode #(
        .FLD2_525    (FLD2_525),    .FLD2_625    (FLD2_625),
        .HS_LEN      (HS_LEN),      .VS_OFS      (VS_OFS),
        .VS_LINES    (VS_LINES),    .ACT_LEN     (ACT_LEN),
        .ACT_525     (ACT_525),     .ACT_625     (ACT_625),
        .VB_END_525  (VB_END_525),  .VB2_END_525 (VB2_END_525),
        .VB_HEAD_625 (VB_HEAD_625), .VB_END_625  (VB_END_625),
        .VB2_BEG_625 (VB2_BEG_625), .VB2_END_625 (VB2_END_625),
        .SW          (SW),          .LW          (LW)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_625   (std_625),
        .master    (master),
        .hsel      (hsel),
        .sync_neg  (sync_neg),
        .par_inv   (par_inv),
        .stopped   (stopped),
        .sample_no (sample_no),
        .line_no   (line_no),
        .sync_out  (sync_out),
        .fp_out    (fp_out),
        .vblank    (vblank),
        .active    (active)
    );

    assign black = stopped;
    assign fp_oe = master;

    assert_black_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        black |-> (sync_out == sync_neg));
    assert_parity_at_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sample_no != '0) && $stable(par_inv) && $stable(std_625)) |-> $stable(fp_out));
endmodule

// File: tb/frame_timing_gen_test.sv
// Directed bench with shortened geometry; each task checks its own scenario.
module frame_timing_gen_test;
    localparam int S5 = 40, N5 = 21, S6 = 48, N6 = 25;
    localparam int F2_5 = 11, F2_6 = 13;
    localparam int HSL = 6, VSO = 1, VSL = 2;
    localparam int ALEN = 20, AS5 = 10, AS6 = 12;
    localparam int VBE5 = 3, VB2E5 = 13, VBH6 = 24, VBE6 = 2, VB2B6 = 12, VB2E6 = 15;
    localparam int LOSTF = 3;
    localparam int SWT = $clog2(S6);
    localparam int LWT = $clog2(N6 + 1);

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
    logic std_625 = 1'b0, master = 1'b0, freerun_en = 1'b0, par_inv = 1'b0;
    logic sync_neg = 1'b0, hsel = 1'b1, fp_in = 1'b0;
    logic fp_out, fp_oe, sync_out, vblank, active, black, locked;
    logic [2:0] burst_phase;
    logic [LWT-1:0] line_no;
    logic [SWT-1:0] sample_no;

    int checks = 0, errors = 0, t = 0;

    always #4 clk = ~clk;

    frame_timing_gen #(
        .SAMPLES_525(S5), .LINES_525(N5), .SAMPLES_625(S6), .LINES_625(N6),
        .FLD2_525(F2_5), .FLD2_625(F2_6), .HS_LEN(HSL), .VS_OFS(VSO), .VS_LINES(VSL),
        .ACT_LEN(ALEN), .ACT_525(AS5), .ACT_625(AS6),
        .VB_END_525(VBE5), .VB2_END_525(VB2E5), .VB_HEAD_625(VBH6), .VB_END_625(VBE6),
        .VB2_BEG_625(VB2B6), .VB2_END_625(VB2E6), .LOST_FRAMES(LOSTF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .std_625(std_625), .master(master),
        .freerun_en(freerun_en), .par_inv(par_inv), .sync_neg(sync_neg), .hsel(hsel),
        .fp_in(fp_in), .fp_out(fp_out), .fp_oe(fp_oe), .sync_out(sync_out), .vblank(vblank),
        .active(active), .black(black), .burst_phase(burst_phase), .line_no(line_no),
        .sample_no(sample_no), .locked(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_soft_rst();
        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        t = 0;
    endtask

    // Compare every output against the timing model for n cycles.
    task automatic sweep(input int n, input bit wiggle);
        for (int i = 0; i < n; i++) begin
            int lpl, nl, f2, frm, s, ln, rel, bp, st;
            bit blank, f2f, hs, vs, lost, stop, syn, act;
            lpl = std_625 ? S6 : S5;
            nl  = std_625 ? N6 : N5;
            f2  = std_625 ? F2_6 : F2_5;
            frm = lpl * nl;
            s   = t % lpl;
            ln  = (t / lpl) % nl + 1;
            if (std_625)
                blank = (ln >= VBH6) || (ln <= VBE6) || (ln >= VB2B6 && ln <= VB2E6);
            else
                blank = (ln <= VBE5) || (ln >= F2_5 && ln <= VB2E5);
            f2f  = ln >= f2;
            bp   = ((t / frm) * 2 + int'(f2f)) % (std_625 ? 8 : 4);
            rel  = f2f ? ln - f2 : ln - 1;
            vs   = (rel >= VSO) && (rel < VSO + VSL);
            hs   = s < HSL;
            lost = !master && (t >= (LOSTF + 1) * frm);
            stop = lost && !freerun_en;
            syn  = (stop ? 1'b0 : (hsel ? hs : (hs ^ vs))) ^ sync_neg;
            st   = (std_625 ? AS6 : AS5) + (master ? 2 : 0);
            act  = !blank && (s >= st) && (s < st + ALEN);
            chk("R1 sample_no", int'(sample_no), s);
            chk("R1 line_no", int'(line_no), ln);
            chk("R2 vblank", int'(vblank), int'(blank));
            chk("R4 fp_out", int'(fp_out), int'(f2f ^ par_inv));
            chk("R5 burst_phase", int'(burst_phase), bp);
            chk("R8 sync_out", int'(sync_out), int'(syn));
            chk("R9 active", int'(active), int'(act));
            chk("R7 locked", int'(locked), int'(!master && !lost));
            chk("R7 black", int'(black), int'(stop));
            if (wiggle && (i % 37 == 0)) fp_in = ~fp_in;
            step(1);
            t++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(5);
        rst_n = 1'b1;
        step(1);
        chk("R6 reset line", int'(line_no), 1);
        chk("R6 reset sample", int'(sample_no), 0);
        chk("R6 reset black", int'(black), 1);
        chk("R7 reset locked", int'(locked), 0);
        chk("R3 reset fp_oe", int'(fp_oe), 0);
        chk("R6 reset sync idle", int'(sync_out), 0);
    endtask

    // Slave: parked until falling edge, rising edge ignored, edge restarts.
    task automatic t_slave_acquire();
        master = 1'b0; std_625 = 1'b0; par_inv = 1'b0; freerun_en = 1'b0; hsel = 1'b1;
        fp_in = 1'b1;
        step(4);
        pulse_soft_rst();
        step(50);
        chk("R6 parked line", int'(line_no), 1);
        chk("R6 parked sample", int'(sample_no), 0);
        chk("R6 parked black", int'(black), 1);
        chk("R6 parked sync", int'(sync_out), 0);
        chk("R3 slave fp_oe", int'(fp_oe), 0);
        fp_in = 1'b0;
        step(2);
        chk("R6 not yet restarted", int'(black), 1);
        step(1);
        t = 0;
        chk("R6 edge start line", int'(line_no), 1);
        chk("R6 edge start sample", int'(sample_no), 0);
        sweep(100, 1'b0);
        fp_in = 1'b1;
        sweep(200, 1'b0);
        fp_in = 1'b0;
        step(3);
        t = 0;
        chk("R6 restart line", int'(line_no), 1);
        chk("R6 restart sample", int'(sample_no), 0);
        chk("R6 restart locked", int'(locked), 1);
    endtask

    // Slave loss with free-run off: black and silent sync after three frames.
    task automatic t_slave_loss_black();
        sweep((LOSTF + 1) * S5 * N5 + 50, 1'b0);
        chk("R7 lost locked", int'(locked), 0);
        chk("R7 lost black", int'(black), 1);
    endtask

    // Relock on rising edge with par_inv=1, then loss with free-run on.
    task automatic t_slave_freerun();
        freerun_en = 1'b1;
        par_inv = 1'b1;
        step(6);
        t = t + 6;
        fp_in = 1'b1;
        step(3);
        t = 0;
        chk("R6 rising edge restart line", int'(line_no), 1);
        chk("R6 rising edge restart sample", int'(sample_no), 0);
        chk("R7 relock", int'(locked), 1);
        chk("R7 relock black", int'(black), 0);
        sweep((LOSTF + 1) * S5 * N5 + 50, 1'b0);
        chk("R7 freerun locked", int'(locked), 0);
        chk("R7 freerun black", int'(black), 0);
        par_inv = 1'b0;
    endtask

    // Master 525 with composite sync; fp_in toggling must not disturb timing.
    task automatic t_master_525();
        master = 1'b1; std_625 = 1'b0; hsel = 1'b0; sync_neg = 1'b0; par_inv = 1'b0;
        pulse_soft_rst();
        chk("R3 master start line", int'(line_no), 1);
        chk("R3 master start sample", int'(sample_no), 0);
        chk("R3 master fp_oe", int'(fp_oe), 1);
        sweep(2 * S5 * N5 + 10, 1'b1);
    endtask

    // Master 625, inverted parity and sync, line sync only, full 8-field run.
    task automatic t_master_625();
        master = 1'b1; std_625 = 1'b1; hsel = 1'b1; sync_neg = 1'b1; par_inv = 1'b1;
        pulse_soft_rst();
        sweep(4 * S6 * N6 + 10, 1'b1);
        pulse_soft_rst();
        chk("R5 burst clear on restart", int'(burst_phase), 0);
        step(5);
        chk("R3 master count after restart", int'(sample_no), 5);
    endtask

    initial begin
        t_reset();
        t_slave_acquire();
        t_slave_loss_black();
        t_slave_freerun();
        t_master_525();
        t_master_625();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule